// File: doc/BRIEF.md
# Ethernet status LED driver

This block drives a single status LED for a 10 Mb/s Ethernet controller. A small control register holds one enable bit for each activity source. The sources are transmit, receive, receive with address match, collision, jabber, link state and receive polarity. Each enabled source is qualified by its own mode and timing rules. The qualified sources are ORed into one combined event.

An optional retriggerable pulse stretcher keeps the LED lit for a programmed number of clock cycles after each new event. This makes short bursts visible. The stretched value is the LED output bit, and the board pin is its active-low copy. The unstretched combined event can be read back as a status bit next to the enables.

Software writes the eight enable bits through a simple write strobe and can read them back at any cycle. A hard reset restores defaults. A soft reset or a stop command only discards a pending stretch, and never touches the enables.

Top module: `led_status_drv`

## Requirements
- R1: While and right after `hrst_n` is low, `cfg_rdata[7:0]` reads 8'h03 (stretch enable bit 0 and transmit enable bit 1 set, all others clear), and the stretch counter is empty.
- R2: A cycle with `cfg_we` high loads `cfg_wdata` into the enables, and `cfg_rdata[7:0]` shows it from the next cycle on. A cycle without `cfg_we` leaves the enables unchanged.
- R3: `srst` and `stop_cmd` never change `cfg_rdata[7:0]`.
- R4: `cfg_rdata[8]` is the unstretched event in the same cycle. Transmit (bit 1) contributes `tx_active`, receive (bit 2) contributes `rx_active`, and jabber (bit 5) contributes `jabber`. A disabled source contributes 0.
- R5: Match (bit 3) contributes only when `rx_active` and `rx_match` are both high.
- R6: Link (bit 6) contributes `link_pass`, and contributes 0 whenever `full_duplex` is high.
- R7: Polarity (bit 7) contributes 1 only when `link_pass` is high and `pol_rev` is low.
- R8: Collision (bit 4) contributes `col_in`, except during a blanking window. The window is the cycle in which `tx_active` is first seen low after being high, plus the following CLK_MHZ*SQE_US cycles (500 at defaults).
- R9: With bit 0 clear, `led_out` equals `cfg_rdata[8]` in every cycle.
- R10: With bit 0 set, a rising edge of the event reloads a counter to STRETCH_CYC. `led_out` is high while the event or the counter is non-zero. A one-cycle event lights the LED for STRETCH_CYC+1 cycles, and a new event restarts the count.
- R11: `led_n` is always the inverse of `led_out`.
- R12: A cycle with `srst` or `stop_cmd` high empties the stretch counter, so in the next cycle `led_out` equals the unstretched event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hrst_n | input | 1 | Hard reset, asynchronous, active low |
| srst | input | 1 | Soft reset strobe |
| stop_cmd | input | 1 | Stop command strobe |
| cfg_we | input | 1 | Enable register write strobe |
| cfg_wdata | input | 8 | Enable bits to write |
| cfg_rdata | output | 9 | Readback: bit 8 unstretched event, bits 7:0 enables |
| tx_active | input | 1 | Transmission in progress |
| rx_active | input | 1 | Receive activity on the wire |
| rx_match | input | 1 | Current receive passed address matching |
| col_in | input | 1 | Collision input |
| jabber | input | 1 | Transmitter is jabbering |
| link_pass | input | 1 | Twisted-pair link in pass state |
| full_duplex | input | 1 | Twisted-pair port runs full duplex |
| pol_rev | input | 1 | Receive pair polarity reversed |
| led_out | output | 1 | Stretched LED state, active high |
| led_n | output | 1 | LED pin, active low |

## Verification
The hardest case to reach is the edge of the collision blanking window. The stimulus ends a transmission while `col_in` is held high, then counts cycles from the bench. It samples the last blanked cycle and the first unblanked cycle, so an off-by-one in either direction is caught. For the stretcher, the bench times a second event to land inside a running stretch. It then checks that the LED is still lit at the restarted deadline, which lies well past the original one, and that it goes dark one cycle later.

// File: rtl/led_pkg.sv
package led_pkg;
  localparam int EN_W = 8;
  localparam int B_STR = 0;
  localparam int B_TX  = 1;
  localparam int B_RX  = 2;
  localparam int B_MAT = 3;
  localparam int B_COL = 4;
  localparam int B_JAB = 5;
  localparam int B_LNK = 6;
  localparam int B_POL = 7;
  localparam logic [EN_W-1:0] EN_RESET = 8'h03;
  localparam int NSRC = 7;

  typedef struct packed {
    logic pol;
    logic lnk;
    logic jab;
    logic col;
    logic mat;
    logic rx;
    logic tx;
    logic str;
  } led_en_t;
endpackage

// File: rtl/led_cfg_reg.sv
module led_cfg_reg
  import led_pkg::*;
(
  input  logic            clk,
  input  logic            hrst_n,
  input  logic            we,
  input  logic [EN_W-1:0] wdata,
  output led_en_t         en
);
  led_en_t en_q;

  always_ff @(posedge clk or negedge hrst_n) begin
    if (!hrst_n)  en_q <= led_en_t'(EN_RESET);
    else if (we)  en_q <= led_en_t'(wdata);
  end

  assign en = en_q;
endmodule

// File: rtl/led_sqe_blank.sv
module led_sqe_blank #(
  parameter int WIN_CYC = 500
) (
  input  logic clk,
  input  logic hrst_n,
  input  logic tx_active,
  output logic blank
);
  localparam int CW = $clog2(WIN_CYC + 1);
  localparam logic [CW-1:0] WIN_V = CW'(WIN_CYC);

  logic          tx_q;
  logic [CW-1:0] win_q;
  logic          tx_fall;

  assign tx_fall = tx_q & ~tx_active;

  always_ff @(posedge clk or negedge hrst_n) begin
    if (!hrst_n) begin
      tx_q  <= 1'b0;
      win_q <= '0;
    end else begin
      tx_q <= tx_active;
      if (tx_fall)            win_q <= WIN_V;
      else if (win_q != '0)   win_q <= win_q - 1'b1;
    end
  end

  assign blank = tx_fall | (win_q != '0);
endmodule

// File: rtl/led_src_or.sv
module led_src_or #(
  parameter int NSRC = 7
) (
  input  logic [NSRC-1:0] hit,
  input  logic [NSRC-1:0] mask,
  output logic            raw
);
  logic [NSRC-1:0] gated;

  for (genvar i = 0; i < NSRC; i++) begin : g_gate
    assign gated[i] = hit[i] & mask[i];
  end

  assign raw = |gated;
endmodule

// File: rtl/led_stretch.sv
module led_stretch #(
  parameter int HOLD_CYC = 32
) (
  input  logic clk,
  input  logic hrst_n,
  input  logic clr,
  input  logic stretch_en,
  input  logic raw,
  output logic led
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYC);

  logic          raw_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge hrst_n) begin
    if (!hrst_n) begin
      raw_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      raw_q <= raw;
      if (clr)                 cnt_q <= '0;
      else if (raw && !raw_q)  cnt_q <= HOLD_V;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end
  end

  assign led = stretch_en ? (raw | (cnt_q != '0)) : raw;
endmodule

// File: rtl/led_status_drv.sv
module led_status_drv
  import led_pkg::*;
#(
  parameter int CLK_MHZ     = 125,
  parameter int SQE_US      = 4,
  parameter int STRETCH_CYC = 32
) (
  input  logic       clk,
  input  logic       hrst_n,
  input  logic       srst,
  input  logic       stop_cmd,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output logic [8:0] cfg_rdata,
  input  logic       tx_active,
  input  logic       rx_active,
  input  logic       rx_match,
  input  logic       col_in,
  input  logic       jabber,
  input  logic       link_pass,
  input  logic       full_duplex,
  input  logic       pol_rev,
  output logic       led_out,
  output logic       led_n
);
  localparam int SQE_CYC = CLK_MHZ * SQE_US;

  led_en_t         en;
  logic            blank;
  logic [NSRC-1:0] hit;
  logic [NSRC-1:0] mask;
  logic            raw;

  led_cfg_reg u_cfg (
    .clk    (clk),
    .hrst_n (hrst_n),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .en     (en)
  );

  led_sqe_blank #(.WIN_CYC(SQE_CYC)) u_sqe (
    .clk       (clk),
    .hrst_n    (hrst_n),
    .tx_active (tx_active),
    .blank     (blank)
  );

  // qualified source conditions, one per enable bit except the stretch bit
  assign hit  = { link_pass & ~pol_rev,
                  link_pass & ~full_duplex,
                  jabber,
                  col_in & ~blank,
                  rx_active & rx_match,
                  rx_active,
                  tx_active };
  assign mask = { en.pol, en.lnk, en.jab, en.col, en.mat, en.rx, en.tx };

  led_src_or #(.NSRC(NSRC)) u_or (
    .hit  (hit),
    .mask (mask),
    .raw  (raw)
  );

  led_stretch #(.HOLD_CYC(STRETCH_CYC)) u_str (
    .clk        (clk),
    .hrst_n     (hrst_n),
    .clr        (srst | stop_cmd),
    .stretch_en (en.str),
    .raw        (raw),
    .led        (led_out)
  );

  assign led_n     = ~led_out;
  assign cfg_rdata = {raw, en};
endmodule

// File: rtl/led_status_chk.sv
module led_status_chk (
  input logic       clk,
  input logic       hrst_n,
  input logic       srst,
  input logic       stop_cmd,
  input logic       cfg_we,
  input logic [7:0] cfg_wdata,
  input logic [8:0] cfg_rdata,
  input logic       tx_active,
  input logic       full_duplex,
  input logic       led_out
);
  a_r1_reset_value: assert property (@(posedge clk) $rose(hrst_n) |-> cfg_rdata[7:0] == 8'h03);

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!hrst_n)
    cfg_we |=> cfg_rdata[7:0] == $past(cfg_wdata));

  a_r3_no_write_hold: assert property (@(posedge clk) disable iff (!hrst_n)
    (!cfg_we && (srst || stop_cmd)) |=> $stable(cfg_rdata[7:0]));

  a_r6_fdx_masks_link: assert property (@(posedge clk) disable iff (!hrst_n)
    (cfg_rdata[7:0] == 8'h40 && full_duplex) |-> !cfg_rdata[8]);

  a_r8_blank_on_fall: assert property (@(posedge clk) disable iff (!hrst_n)
    ($fell(tx_active) && cfg_rdata[7:0] == 8'h10) |-> !cfg_rdata[8]);

  a_r9_no_stretch: assert property (@(posedge clk) disable iff (!hrst_n)
    !cfg_rdata[0] |-> led_out == cfg_rdata[8]);

  a_r10_event_lights: assert property (@(posedge clk) disable iff (!hrst_n)
    cfg_rdata[8] |-> led_out);

  a_r12_clear_stretch: assert property (@(posedge clk) disable iff (!hrst_n)
    (srst || stop_cmd) |=> led_out == cfg_rdata[8]);
endmodule

bind led_status_drv led_status_chk u_chk (.*);

// File: tb/tb_led_status_drv.sv
module tb_led_status_drv;
  localparam int HOLD = 32;
  localparam int WIN  = 500;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       hrst_n = 1'b0, srst = 1'b0, stop_cmd = 1'b0, cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [8:0] cfg_rdata;
  logic       tx_active = 0, rx_active = 0, rx_match = 0, col_in = 0;
  logic       jabber = 0, link_pass = 0, full_duplex = 0, pol_rev = 0;
  logic       led_out, led_n;

  led_status_drv dut (.*);

  typedef struct {
    string      tag;
    logic       led;
    logic       raw;
    logic [7:0] en;
  } exp_t;

  exp_t       sb[$];
  int         checks = 0;
  int         errors = 0;
  logic [7:0] en_m = 8'h03;
  bit         done = 0;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(string tag, logic led, logic raw);
    exp_t e;
    e.tag = tag; e.led = led; e.raw = raw; e.en = en_m;
    sb.push_back(e);
  endtask

  task automatic wr(logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    tick();
    cfg_we = 1'b0;
    en_m = v;
  endtask

  // monitor: pops expectations half a cycle after the driver
  always @(negedge clk) begin
    exp_t        e;
    logic [10:0] got, exp;
    while (sb.size() > 0) begin
      e   = sb.pop_front();
      got = {led_n, led_out, cfg_rdata};
      exp = {~e.led, e.led, e.raw, e.en};
      checks++;
      if (got !== exp) begin
        errors++;
        $display("FAIL %s got %h expected %h", e.tag, got, exp);
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    expect_out("R1 in reset", 1'b0, 1'b0);
    tick();
    hrst_n = 1'b1;
    expect_out("R1 after reset", 1'b0, 1'b0);
    tick();

    // R2 write and read back
    wr(8'hA4);
    expect_out("R2 readback", 1'b0, 1'b0);
    tick();
    expect_out("R2 hold", 1'b0, 1'b0);

    // R4 transmit, receive, jabber, stretch off
    wr(8'h02);
    tx_active = 1; expect_out("R4 tx on", 1, 1); tick();
    rx_active = 1; tx_active = 0; expect_out("R4 rx while disabled", 0, 0); tick();
    wr(8'h04);
    expect_out("R4 rx on", 1, 1); tick();
    rx_active = 0; expect_out("R9 follows raw", 0, 0); tick();
    wr(8'h20);
    jabber = 1; expect_out("R4 jabber", 1, 1); tick();
    jabber = 0;

    // R5 match
    wr(8'h08);
    rx_active = 1; expect_out("R5 no match", 0, 0); tick();
    rx_match = 1; expect_out("R5 match", 1, 1); tick();
    rx_active = 0; rx_match = 0;

    // R6 link
    wr(8'h40);
    link_pass = 1; expect_out("R6 link pass", 1, 1); tick();
    full_duplex = 1; expect_out("R6 full duplex mask", 0, 0); tick();
    full_duplex = 0; link_pass = 0; expect_out("R6 link fail", 0, 0); tick();

    // R7 polarity
    wr(8'h80);
    link_pass = 1; expect_out("R7 normal polarity", 1, 1); tick();
    pol_rev = 1; expect_out("R7 reversed", 0, 0); tick();
    pol_rev = 0; link_pass = 0; expect_out("R7 link fail", 0, 0); tick();

    // R8 collision and SQE window
    repeat (WIN + 2) tick();
    wr(8'h10);
    col_in = 1; expect_out("R8 collision", 1, 1); tick();
    col_in = 0; tx_active = 1; tick();
    tx_active = 0; col_in = 1; expect_out("R8 fall cycle blanked", 0, 0);
    repeat (WIN - 1) tick();
    tick(); expect_out("R8 last blanked cycle", 0, 0);
    tick(); expect_out("R8 window over", 1, 1);
    tick();
    col_in = 0;

    // R10 stretch, single event
    wr(8'h05);
    rx_active = 1; expect_out("R10 event", 1, 1); tick();
    rx_active = 0; expect_out("R10 stretched", 1, 0);
    repeat (HOLD - 1) tick();
    expect_out("R10 last lit cycle", 1, 0); tick();
    expect_out("R10 expired", 0, 0); tick();

    // R10 retrigger
    rx_active = 1; tick();
    rx_active = 0; repeat (9) tick();
    rx_active = 1; expect_out("R10 retrigger", 1, 1); tick();
    rx_active = 0;
    repeat (HOLD - 1) tick();
    expect_out("R10 restarted deadline", 1, 0); tick();
    expect_out("R10 restarted expiry", 0, 0); tick();

    // R12 and R3: soft reset and stop
    rx_active = 1; tick();
    rx_active = 0; tick();
    srst = 1; expect_out("R12 srst cycle", 1, 0); tick();
    srst = 0; expect_out("R12 R3 after srst", 0, 0); tick();
    rx_active = 1; tick();
    rx_active = 0; tick();
    stop_cmd = 1; expect_out("R12 stop cycle", 1, 0); tick();
    stop_cmd = 0; expect_out("R12 R3 after stop", 0, 0); tick();

    // R1 hard reset restores defaults
    hrst_n = 0; en_m = 8'h03; tick();
    expect_out("R1 hard reset again", 0, 0); tick();
    hrst_n = 1; tick();
    tx_active = 1; expect_out("R11 R1 default tx", 1, 1); tick();
    tx_active = 0; tick();

    @(negedge clk); #1;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule